// File: doc/BRIEF.md
# I2C Master Control and Status Register Block

This block is the software-visible face of a FIFO-based I2C master. It sits between a simple register read/write port and the serial bus engine. It decodes word-aligned register offsets and keeps the control word with its per-event interrupt enables. It assembles a status word from latched events and from live conditions reported by the engine and the two FIFOs. It also drives a single level-sensitive interrupt line.

Two status events, transfer completion and lost arbitration, are latched when the engine pulses them. They stay set until software writes a one to the same bit position. The missing-acknowledge flag is latched too, but only a new START or a soft reset clears it. Writing the reset bit of the control word starts a flush sequence. The bit keeps reading as one until both FIFOs are empty and the bus has gone quiet, and then it clears itself. The transmit data port pushes a 10-bit command word (data byte plus START and STOP flags) into the transmit FIFO. The receive data port pops one byte.

Top module: `i2cm_reg_block`

## Requirements
- R1: After reset the control word reads 0, the three latched flags are 0 and `irq` is low. With SCL, SDA, receive-empty and transmit-empty high and every other input low, status (offset 0x04) reads 0x0AC0.
- R2: A one-cycle pulse on `ev_done` sets status bit 0, and one on `ev_arb_lost` sets bit 1. Each bit holds until a status write carries a 1 in that position. A status write carrying 0 there leaves it set.
- R3: When an event pulse and a write-one-to-clear of the same bit happen in the same cycle, the bit is set afterwards.
- R4: A pulse on `ev_nack` sets status bit 2. A pulse on `ev_start` (with no `ev_nack` that cycle) or a completed soft reset clears it. Status writes never change it.
- R5: The live status bits mirror their inputs: bit 3 data request, bit 5 bus active, bit 6 SCL, bit 7 SDA, bit 8 receive full, bit 9 receive empty, bit 10 transmit full, bit 11 transmit empty. Bit 4 and bits 12 and up read 0.
- R6: At control offset 0x08, bits 0 to 7 are the enables (0 done, 1 arbitration, 2 no-ack, 3 data request, 4 slave request, 5 receive full, 6 receive data available, 7 transmit full) and bit 10 is the mode flag. They read back as written. Bits 9 and 11 and up read 0. Bit 4 and bit 10 drive `slave_req_en` and `mode_flag`.
- R7: Writing 1 to control bit 8 raises `fifo_flush`, and bit 8 reads 1 for at least two cycles. It clears at the first clock edge after that in which both FIFOs are empty and the bus is inactive. Completion and arbitration flags are also held clear while it is set.
- R8: `irq` is high exactly when some enabled source is true: done, arbitration, no-ack, data request, receive full or transmit full. With all enables 0, `irq` stays low.
- R9: With enable bit 6 set, `irq` is high whenever the receive FIFO is not empty.
- R10: A write to offset 0x00 pulses `tx_push` in that cycle with `tx_word` equal to write-data bits 9:0. A read of offset 0x00 pulses `rx_pop` and returns the received byte in bits 7:0.
- R11: Offsets 0x0C and 0x10 hold the low and high clock dividers (10 bits), and 0x14 holds the 7-bit own address. Each reads back as written and drives its output.
- R12: Offsets 0x18, 0x1C, 0x20 and 0x24 return the receive level, transmit level, received-byte count and transmitted-byte count.
- R13: Reads of unmapped offsets (0x28 and above) return 0. Writes to the read-only offsets 0x18 to 0x24 and to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| ev_done | input | 1 | Transfer-complete pulse from engine |
| ev_arb_lost | input | 1 | Arbitration-lost pulse |
| ev_nack | input | 1 | Missing-acknowledge pulse |
| ev_start | input | 1 | New START issued pulse |
| data_req | input | 1 | Engine waiting for next transmit word |
| bus_active | input | 1 | Bus busy level |
| scl_in | input | 1 | Live SCL level |
| sda_in | input | 1 | Live SDA level |
| rx_full | input | 1 | Receive FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_bytes | input | CNT_W | Bytes received |
| tx_bytes | input | CNT_W | Bytes transmitted |
| rx_data | input | 8 | Head of receive FIFO |
| tx_push | output | 1 | Push strobe into transmit FIFO |
| tx_word | output | 10 | Transmit command word |
| rx_pop | output | 1 | Pop strobe from receive FIFO |
| fifo_flush | output | 1 | Flush both FIFOs and idle the engine |
| clk_lo_div | output | DIV_W | SCL low-phase divider |
| clk_hi_div | output | DIV_W | SCL high-phase divider |
| own_addr | output | OWN_W | Own bus address |
| slave_req_en | output | 1 | Slave data-request enable |
| mode_flag | output | 1 | Mode flag from control bit 10 |
| irq | output | 1 | Level interrupt |

## Verification
The bench hits an event pulse in the same cycle as its write-one-to-clear; a design that lets the clear win would drop a completion. It starts a soft reset while the transmit FIFO is still non-empty and checks that the reset bit stays up until the FIFO drains. It also checks that the bit is not cleared in the first cycle even when everything is already idle; a design that freed it early would let software touch FIFOs mid-flush. It writes all ones to the status word to confirm the no-ack flag survives, and reads both unmapped offsets and read-only offsets after writes to catch decode aliasing.

// File: rtl/i2cm_regs_pkg.sv
package i2cm_regs_pkg;

  // status bit positions
  localparam int ST_DONE   = 0;
  localparam int ST_ARB    = 1;
  localparam int ST_NACK   = 2;
  localparam int ST_DRQ    = 3;
  localparam int ST_ACTIVE = 5;
  localparam int ST_SCL    = 6;
  localparam int ST_SDA    = 7;
  localparam int ST_RXF    = 8;
  localparam int ST_RXE    = 9;
  localparam int ST_TXF    = 10;
  localparam int ST_TXE    = 11;
  localparam int ST_W      = 12;

  // control bit positions
  localparam int CT_IE_W   = 8;
  localparam int CT_SLV    = 4;
  localparam int CT_RESET  = 8;
  localparam int CT_MODE   = 10;

  // word indices of the register map
  localparam int OFF_DATA  = 0;
  localparam int OFF_STAT  = 1;
  localparam int OFF_CTRL  = 2;
  localparam int OFF_CKLO  = 3;
  localparam int OFF_CKHI  = 4;
  localparam int OFF_OWN   = 5;
  localparam int OFF_RXLVL = 6;
  localparam int OFF_TXLVL = 7;
  localparam int OFF_RXCNT = 8;
  localparam int OFF_TXCNT = 9;

  typedef enum logic [1:0] {SR_IDLE, SR_FLUSH, SR_WAIT} srst_state_t;

  typedef struct packed {
    logic txe, txf, rxe, rxf, sda, scl, active, rsv4, drq, nack, arb, done;
  } status_t;

  // interrupt sources aligned to enable bits; slave-request enable is not a source
  function automatic logic irq_reduce(input logic [CT_IE_W-1:0] en,
                                      input logic [CT_IE_W-1:0] cond);
    logic [CT_IE_W-1:0] live;
    live = en & cond;
    live[CT_SLV] = 1'b0;
    return |live;
  endfunction

  function automatic logic [11:0] ctrl_word(input logic [CT_IE_W-1:0] ie,
                                             input logic busy, input logic mode);
    return {mode, 1'b0, busy, ie};
  endfunction

endpackage

// File: rtl/i2cm_sticky_flags.sv
module i2cm_sticky_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_hold,
  input  logic clr_done,
  input  logic clr_arb,
  input  logic ev_done,
  input  logic ev_arb,
  input  logic ev_nack,
  input  logic ev_start,
  output logic done_q,
  output logic arb_q,
  output logic nack_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      arb_q  <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      if (ev_done) done_q <= 1'b1;
      else if (clr_done || srst_hold) done_q <= 1'b0;
      if (ev_arb) arb_q <= 1'b1;
      else if (clr_arb || srst_hold) arb_q <= 1'b0;
      if (ev_nack) nack_q <= 1'b1;
      else if (ev_start || srst_hold) nack_q <= 1'b0;
    end
  end

  assert_w1c_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && !ev_done) |=> !done_q);
  assert_hold_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_done && !clr_done && !srst_hold) |=> $stable(done_q));
  assert_event_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_arb && clr_arb) |=> arb_q);
  assert_nack_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !ev_nack) |=> !nack_q);

endmodule

// File: rtl/i2cm_soft_reset.sv
module i2cm_soft_reset
  import i2cm_regs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic rx_empty,
  input  logic tx_empty,
  input  logic bus_active,
  output logic busy
);

  srst_state_t state_q;
  logic        quiet;

  assign quiet = rx_empty && tx_empty && !bus_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SR_IDLE;
    else begin
      case (state_q)
        SR_IDLE:  if (start_req) state_q <= SR_FLUSH;
        SR_FLUSH: state_q <= SR_WAIT;
        SR_WAIT:  if (quiet) state_q <= SR_IDLE;
        default:  state_q <= SR_IDLE;
      endcase
    end
  end

  assign busy = (state_q != SR_IDLE);

  assert_srst_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
  assert_srst_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SR_WAIT && !quiet) |=> busy);
  assert_srst_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_req) |=> busy);

endmodule

// File: rtl/i2cm_irq_combine.sv
module i2cm_irq_combine
  import i2cm_regs_pkg::*;
(
  input  logic [CT_IE_W-1:0] ie,
  input  logic [CT_IE_W-1:0] cond,
  output logic               irq
);
  assign irq = irq_reduce(ie, cond);
endmodule

// File: rtl/i2cm_reg_block.sv
module i2cm_reg_block
  import i2cm_regs_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DIV_W = 10,
  parameter int OWN_W = 7,
  parameter int LVL_W = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ev_done,
  input  logic             ev_arb_lost,
  input  logic             ev_nack,
  input  logic             ev_start,
  input  logic             data_req,
  input  logic             bus_active,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             rx_full,
  input  logic             rx_empty,
  input  logic             tx_full,
  input  logic             tx_empty,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_bytes,
  input  logic [CNT_W-1:0] tx_bytes,
  input  logic [7:0]       rx_data,
  output logic             tx_push,
  output logic [9:0]       tx_word,
  output logic             rx_pop,
  output logic             fifo_flush,
  output logic [DIV_W-1:0] clk_lo_div,
  output logic [DIV_W-1:0] clk_hi_div,
  output logic [OWN_W-1:0] own_addr,
  output logic             slave_req_en,
  output logic             mode_flag,
  output logic             irq
);

  localparam int WW = AW - 2;

  logic [WW-1:0]      widx;
  logic               wr_stat, wr_ctrl, srst_busy, srst_req;
  logic               done_q, arb_q, nack_q, mode_q;
  logic [CT_IE_W-1:0] ie_q, irq_cond;
  logic [DIV_W-1:0]   lo_q, hi_q;
  logic [OWN_W-1:0]   own_q;
  status_t            stat;
  logic               unused_bits;

  assign widx        = reg_addr[AW-1:2];
  assign unused_bits = ^{reg_addr[1:0], reg_wdata[31:12], reg_wdata[9]};
  assign wr_stat     = reg_wr && (widx == WW'(OFF_STAT));
  assign wr_ctrl     = reg_wr && (widx == WW'(OFF_CTRL));
  assign srst_req    = wr_ctrl && reg_wdata[CT_RESET];
  assign tx_push     = reg_wr && (widx == WW'(OFF_DATA));
  assign tx_word     = reg_wdata[9:0];
  assign rx_pop      = reg_rd && (widx == WW'(OFF_DATA));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= '0;
      mode_q <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
      own_q  <= '0;
    end else if (reg_wr) begin
      case (widx)
        WW'(OFF_CTRL): begin
          ie_q   <= reg_wdata[CT_IE_W-1:0];
          mode_q <= reg_wdata[CT_MODE];
        end
        WW'(OFF_CKLO): lo_q  <= reg_wdata[DIV_W-1:0];
        WW'(OFF_CKHI): hi_q  <= reg_wdata[DIV_W-1:0];
        WW'(OFF_OWN):  own_q <= reg_wdata[OWN_W-1:0];
        default: ;
      endcase
    end
  end

  i2cm_sticky_flags u_flags (
    .clk(clk), .rst_n(rst_n), .srst_hold(srst_busy),
    .clr_done(wr_stat && reg_wdata[ST_DONE]),
    .clr_arb(wr_stat && reg_wdata[ST_ARB]),
    .ev_done(ev_done), .ev_arb(ev_arb_lost), .ev_nack(ev_nack),
    .ev_start(ev_start),
    .done_q(done_q), .arb_q(arb_q), .nack_q(nack_q)
  );

  i2cm_soft_reset u_srst (
    .clk(clk), .rst_n(rst_n), .start_req(srst_req),
    .rx_empty(rx_empty), .tx_empty(tx_empty), .bus_active(bus_active),
    .busy(srst_busy)
  );

  assign irq_cond = {tx_full, !rx_empty, rx_full, 1'b0, data_req, nack_q, arb_q, done_q};

  i2cm_irq_combine u_irq (.ie(ie_q), .cond(irq_cond), .irq(irq));

  always_comb begin
    stat = '0;
    stat.done   = done_q;
    stat.arb    = arb_q;
    stat.nack   = nack_q;
    stat.drq    = data_req;
    stat.active = bus_active;
    stat.scl    = scl_in;
    stat.sda    = sda_in;
    stat.rxf    = rx_full;
    stat.rxe    = rx_empty;
    stat.txf    = tx_full;
    stat.txe    = tx_empty;
  end

  always_comb begin
    case (widx)
      WW'(OFF_DATA):  reg_rdata = 32'(rx_data);
      WW'(OFF_STAT):  reg_rdata = 32'(stat);
      WW'(OFF_CTRL):  reg_rdata = 32'(ctrl_word(ie_q, srst_busy, mode_q));
      WW'(OFF_CKLO):  reg_rdata = 32'(lo_q);
      WW'(OFF_CKHI):  reg_rdata = 32'(hi_q);
      WW'(OFF_OWN):   reg_rdata = 32'(own_q);
      WW'(OFF_RXLVL): reg_rdata = 32'(rx_level);
      WW'(OFF_TXLVL): reg_rdata = 32'(tx_level);
      WW'(OFF_RXCNT): reg_rdata = 32'(rx_bytes);
      WW'(OFF_TXCNT): reg_rdata = 32'(tx_bytes);
      default:        reg_rdata = '0;
    endcase
  end

  assign fifo_flush   = srst_busy;
  assign clk_lo_div   = lo_q;
  assign clk_hi_div   = hi_q;
  assign own_addr     = own_q;
  assign slave_req_en = ie_q[CT_SLV];
  assign mode_flag    = mode_q;

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |-> !irq);
  assert_irq_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q[ST_DONE] && done_q) |-> irq);
  assert_irq_rxavail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q[6] && !rx_empty) |-> irq);
  assert_unmapped_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (widx > WW'(OFF_TXCNT)) |-> (reg_rdata == '0));
  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_flush && !ev_done) |=> !done_q);

endmodule

// File: tb/i2cm_reg_block_test.sv
module i2cm_reg_block_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reg_wr = 0, reg_rd = 0;
  logic [5:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic ev_done = 0, ev_arb_lost = 0, ev_nack = 0, ev_start = 0;
  logic data_req = 0, bus_active = 0, scl_in = 1, sda_in = 1;
  logic rx_full = 0, rx_empty = 1, tx_full = 0, tx_empty = 1;
  logic [4:0]  rx_level = 0, tx_level = 0;
  logic [15:0] rx_bytes = 0, tx_bytes = 0;
  logic [7:0]  rx_data = 0;
  logic        tx_push, rx_pop, fifo_flush, slave_req_en, mode_flag, irq;
  logic [9:0]  tx_word, clk_lo_div, clk_hi_div;
  logic [6:0]  own_addr;

  i2cm_reg_block uut (.*);

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  int    n_vec = 0, n_bad = 0;
  event  mon_ev;

  // monitor: pops expected read items and compares against the read port
  always begin
    @(mon_ev);
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_vec++;
      if (reg_rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s got %h exp %h", it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic rd_exp(input int word, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1; reg_addr = 6'(word * 4);
    sb.push_back('{exp, tag});
    #2 -> mon_ev;
    #1;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic wr(input int word, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 6'(word * 4); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic pulse(input logic d, input logic a, input logic n, input logic s);
    @(negedge clk);
    ev_done = d; ev_arb_lost = a; ev_nack = n; ev_start = s;
    @(negedge clk);
    ev_done = 0; ev_arb_lost = 0; ev_nack = 0; ev_start = 0;
  endtask

  localparam logic [31:0] ST_BASE = 32'h0000_0AC0;

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_exp(2, 32'h0, "R1 ctrl after reset");
    rd_exp(1, ST_BASE, "R1 status after reset");
    chk(irq, 0, "R1 irq after reset");

    // R2 sticky done/arb, write 0 keeps, write 1 clears
    pulse(1, 1, 0, 0);
    rd_exp(1, ST_BASE | 32'h3, "R2 done+arb latched");
    wr(1, 32'h0);
    rd_exp(1, ST_BASE | 32'h3, "R2 write zero keeps");
    wr(1, 32'h1);
    rd_exp(1, ST_BASE | 32'h2, "R2 w1c done only");
    wr(1, 32'h2);
    rd_exp(1, ST_BASE, "R2 w1c arb");

    // R3 event in same cycle as clear
    @(negedge clk);
    reg_wr = 1; reg_addr = 6'h04; reg_wdata = 32'h3; ev_done = 1; ev_arb_lost = 1;
    @(negedge clk);
    reg_wr = 0; ev_done = 0; ev_arb_lost = 0;
    rd_exp(1, ST_BASE | 32'h3, "R3 event wins over clear");
    wr(1, 32'h3);

    // R4 nack
    pulse(0, 0, 1, 0);
    wr(1, 32'hFFFF_FFFF);
    rd_exp(1, ST_BASE | 32'h4, "R4 nack survives status write");
    pulse(0, 0, 0, 1);
    rd_exp(1, ST_BASE, "R4 start clears nack");

    // R5 live bits
    data_req = 1; bus_active = 1; scl_in = 0; sda_in = 0;
    rx_full = 1; rx_empty = 0; tx_full = 1; tx_empty = 0;
    rd_exp(1, 32'h0000_0528, "R5 live bits inverted pattern");
    data_req = 0; bus_active = 0; scl_in = 1; sda_in = 1;
    rx_full = 0; rx_empty = 1; tx_full = 0; tx_empty = 1;

    // R6 control readback
    wr(2, 32'hFFFF_FEFF);
    rd_exp(2, 32'h0000_04FF, "R6 ctrl writable bits");
    chk(slave_req_en, 1, "R6 slave enable out");
    chk(mode_flag, 1, "R6 mode out");
    wr(2, 32'h0);
    chk(mode_flag, 0, "R6 mode cleared");

    // R8 irq masking
    pulse(1, 0, 0, 0);
    chk(irq, 0, "R8 no enables no irq");
    wr(2, 32'h1);
    chk(irq, 1, "R8 done enabled irq");
    wr(1, 32'h1);
    chk(irq, 0, "R8 irq drops after clear");
    wr(2, 32'h80);
    tx_full = 1; #1;
    chk(irq, 1, "R8 tx full enabled");
    tx_full = 0; #1;
    chk(irq, 0, "R8 tx full gone");

    // R9 rx data available
    wr(2, 32'h40);
    rx_empty = 0; #1;
    chk(irq, 1, "R9 rx available irq");
    rx_empty = 1; #1;
    chk(irq, 0, "R9 rx empty no irq");
    wr(2, 32'h0);

    // R7 soft reset waits for tx drain
    pulse(1, 0, 1, 0);
    tx_empty = 0;
    wr(2, 32'h100);
    rd_exp(2, 32'h100, "R7 reset bit set");
    chk(fifo_flush, 1, "R7 flush asserted");
    rd_exp(2, 32'h100, "R7 reset holds while tx busy");
    tx_empty = 1;
    rd_exp(2, 32'h0, "R7 reset clears after drain");
    chk(fifo_flush, 0, "R7 flush released");
    rd_exp(1, ST_BASE, "R7 R4 flags cleared by soft reset");
    // R7 minimum duration when already idle
    wr(2, 32'h100);
    rd_exp(2, 32'h100, "R7 minimum two cycles");
    rd_exp(2, 32'h0, "R7 idle reset done");

    // R10 data port
    @(negedge clk);
    reg_wr = 1; reg_addr = 6'h00; reg_wdata = 32'hFFFF_F2A5; #2;
    chk(tx_push, 1, "R10 tx push");
    chk(32'(tx_word), 32'h2A5, "R10 tx word");
    @(negedge clk);
    reg_wr = 0; #1;
    chk(tx_push, 0, "R10 push single cycle");
    rx_data = 8'h9C;
    rd_exp(0, 32'h9C, "R10 rx byte read");
    @(negedge clk);
    reg_rd = 1; reg_addr = 6'h00; #2;
    chk(rx_pop, 1, "R10 rx pop strobe");
    @(negedge clk);
    reg_rd = 0; #1;
    chk(rx_pop, 0, "R10 pop released");

    // R11 dividers and own address
    wr(3, 32'hFFFF_F1B3);
    wr(4, 32'h0000_0062);
    wr(5, 32'hFFFF_FFD5);
    rd_exp(3, 32'h1B3, "R11 low divider");
    rd_exp(4, 32'h062, "R11 high divider");
    rd_exp(5, 32'h055, "R11 own address");
    chk(32'(clk_lo_div), 32'h1B3, "R11 low divider out");
    chk(32'(own_addr), 32'h55, "R11 own out");

    // R12 pass-through and R13 read-only writes
    rx_level = 5'd17; tx_level = 5'd3; rx_bytes = 16'hBEEF; tx_bytes = 16'h1234;
    wr(6, 32'hFFFF_FFFF);
    wr(8, 32'h0);
    rd_exp(6, 32'd17, "R12 rx level");
    rd_exp(7, 32'd3, "R12 tx level");
    rd_exp(8, 32'hBEEF, "R12 R13 rx count after ro write");
    rd_exp(9, 32'h1234, "R12 tx count");
    wr(10, 32'hFFFF_FFFF);
    rd_exp(10, 32'h0, "R13 unmapped 0x28");
    rd_exp(15, 32'h0, "R13 unmapped 0x3C");
    rd_exp(2, 32'h0, "R13 ctrl untouched");
    rd_exp(3, 32'h1B3, "R13 divider untouched");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule